// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clock enables are live in a small controller-style system. It has four operating modes: run, wait, doze and stop. From run, the CPU picks a low-power mode with a 2-bit request and issues a one-cycle entry strobe. The block then removes the enables that mode calls for. Peripherals that keep their clock can raise interrupts that bring the system back to run. Stop is the exception: the memory controller and every peripheral lose their clock there, so the only way out of stop is a separate wake input.

A per-peripheral disable vector, written by software, can switch any peripheral's enable off in every mode. A peripheral that is switched off this way cannot wake the system. In doze, the peripherals also see a doze flag and can apply their own doze behaviour. Stop is never entered at once. The controller first passes through a drain state and waits there until the in-progress operation reports that it has finished.

FSM states and transitions:

| State | Reported mode | Leaves when | Goes to |
|---|---|---|---|
| ST_RUN | 00 | strobe with request 01, 10 or 11 | ST_WAIT, ST_DOZE or ST_DRAIN |
| ST_WAIT | 01 | a clocked peripheral raises an interrupt | ST_RUN |
| ST_DOZE | 10 | a clocked peripheral raises an interrupt | ST_RUN |
| ST_DRAIN | 00, with the drain flag high | the completion input goes high | ST_STOP |
| ST_STOP | 11 | the synchronised wake input goes high | ST_RUN |

Top module: `lp_clock_ctrl`

## Requirements
- R1: After reset the mode status is 00 (run), the CPU, SRAM and memory-controller enables are high, each peripheral enable equals the inverse of its disable bit, and the doze flag and drain flag are low.
- R2: The mode changes only when the entry strobe is high while the controller is in run. A strobe with request 00, a strobe in any other state, and a request change without a strobe all leave the mode unchanged.
- R3: In wait (request 01, status 01), the CPU and SRAM enables are low, the memory-controller enable is high, the peripheral enables follow the disable vector, and the doze flag is low.
- R4: In doze (request 10, status 10), the enables are the same as in wait and the doze flag is high.
- R5: In wait or doze, an interrupt from a peripheral whose enable is high returns the controller to run. The CPU and SRAM enables are high in the cycle after the edge that samples the interrupt, and the doze flag is low.
- R6: In wait or doze, an interrupt from a peripheral whose disable bit is set does not wake the controller.
- R7: A peripheral whose disable bit (bit i of the disable vector controls peripheral i) is set has its enable low in every mode.
- R8: A strobe with request 11 enters the drain state. There the drain flag is high, the status stays 00 and all enables stay as in run, until the completion input is high at a clock edge.
- R9: In stop (status 11), every enable is low, including the memory controller and all peripherals, and peripheral interrupts have no effect.
- R10: The stop wake input passes through two synchroniser flops. When it rises before edge n, the status is still 11 after edges n and n+1 and is 00 after edge n+2, with all run enables restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode_req | input | 2 | Requested mode: 00 run, 01 wait, 10 doze, 11 stop |
| lp_enter | input | 1 | One-cycle low-power entry strobe |
| periph_irq | input | NUM_PERIPH | Interrupt request, one per peripheral |
| ppm_disable | input | NUM_PERIPH | Software clock-disable bit, one per peripheral |
| drain_done | input | 1 | In-progress operation has completed |
| stop_wake | input | 1 | Asynchronous wake request for stop |
| cpu_clk_en | output | 1 | CPU clock enable |
| sram_clk_en | output | 1 | On-chip SRAM clock enable |
| memc_clk_en | output | 1 | Memory controller and refresh clock enable |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock enables |
| doze_ind | output | 1 | Doze flag to the peripherals |
| mode_status | output | 2 | Current mode, same encoding as the request |
| drain_busy | output | 1 | High while stop entry is draining |

## Verification
Several properties are checked on every cycle: the gating pattern of each reported mode, the masking of every disabled peripheral, the rule that the drain state keeps all clocks on until completion, the fact that the controller stays in run without a strobe, and the one-cycle return to run after a qualified interrupt. Other behaviours need the bench's scenarios. These are the choice of mode from the request code, the masked interrupts that must not wake, a strobe sent in the wrong state, and the exact three-edge delay from the stop wake input to run.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WAIT,
        ST_DOZE,
        ST_DRAIN,
        ST_STOP
    } lpc_state_e;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_DOZE = 2'b10,
        MODE_STOP = 2'b11
    } lpc_mode_e;

    typedef struct packed {
        logic core_on;
        logic mem_on;
        logic memc_on;
        logic periph_on;
        logic doze;
    } lpc_gate_t;

endpackage

// File: rtl/lpc_wake_sync.sv
module lpc_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
    import lpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    input  logic       enter,
    input  logic       irq_wake,
    input  logic       stop_wake_sync,
    input  logic       drain_done,
    output lpc_gate_t  gate,
    output logic [1:0] mode_status,
    output logic       busy
);
    lpc_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (enter) begin
                    unique case (mode_req)
                        MODE_WAIT: state_d = ST_WAIT;
                        MODE_DOZE: state_d = ST_DOZE;
                        MODE_STOP: state_d = ST_DRAIN;
                        default:   state_d = ST_RUN;
                    endcase
                end
            end
            ST_WAIT:  if (irq_wake)       state_d = ST_RUN;
            ST_DOZE:  if (irq_wake)       state_d = ST_RUN;
            ST_DRAIN: if (drain_done)     state_d = ST_STOP;
            ST_STOP:  if (stop_wake_sync) state_d = ST_RUN;
            default:                      state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        gate        = '{core_on: 1'b1, mem_on: 1'b1, memc_on: 1'b1,
                        periph_on: 1'b1, doze: 1'b0};
        mode_status = MODE_RUN;
        busy        = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_WAIT: begin
                gate.core_on = 1'b0;
                gate.mem_on  = 1'b0;
                mode_status  = MODE_WAIT;
            end
            ST_DOZE: begin
                gate.core_on = 1'b0;
                gate.mem_on  = 1'b0;
                gate.doze    = 1'b1;
                mode_status  = MODE_DOZE;
            end
            ST_DRAIN: busy = 1'b1;
            ST_STOP: begin
                gate        = '0;
                mode_status = MODE_STOP;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_periph_gate.sv
module lpc_periph_gate #(
    parameter int NUM_PERIPH = 4
) (
    input  logic                  periph_on,
    input  logic [NUM_PERIPH-1:0] disable_bits,
    input  logic [NUM_PERIPH-1:0] irq,
    output logic [NUM_PERIPH-1:0] clk_en,
    output logic                  wake_any
);
    logic [NUM_PERIPH-1:0] live_irq;

    genvar g;
    generate
        for (g = 0; g < NUM_PERIPH; g++) begin : g_per
            assign clk_en[g]   = periph_on & ~disable_bits[g];
            assign live_irq[g] = irq[g] & clk_en[g];
        end
    endgenerate

    assign wake_any = |live_irq;
endmodule

// File: rtl/lp_clock_ctrl.sv
module lp_clock_ctrl
    import lpc_pkg::*;
#(
    parameter int NUM_PERIPH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            lp_mode_req,
    input  logic                  lp_enter,
    input  logic [NUM_PERIPH-1:0] periph_irq,
    input  logic [NUM_PERIPH-1:0] ppm_disable,
    input  logic                  drain_done,
    input  logic                  stop_wake,
    output logic                  cpu_clk_en,
    output logic                  sram_clk_en,
    output logic                  memc_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  doze_ind,
    output logic [1:0]            mode_status,
    output logic                  drain_busy
);
    lpc_gate_t gate;
    logic      wake_synced;
    logic      irq_wake;

    lpc_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stop_wake),
        .sync_out (wake_synced)
    );

    lpc_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_req       (lp_mode_req),
        .enter          (lp_enter),
        .irq_wake       (irq_wake),
        .stop_wake_sync (wake_synced),
        .drain_done     (drain_done),
        .gate           (gate),
        .mode_status    (mode_status),
        .busy           (drain_busy)
    );

    lpc_periph_gate #(.NUM_PERIPH(NUM_PERIPH)) u_pgate (
        .periph_on    (gate.periph_on),
        .disable_bits (ppm_disable),
        .irq          (periph_irq),
        .clk_en       (periph_clk_en),
        .wake_any     (irq_wake)
    );

    assign cpu_clk_en  = gate.core_on;
    assign sram_clk_en = gate.mem_on;
    assign memc_clk_en = gate.memc_on;
    assign doze_ind    = gate.doze;
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
    parameter int NUM_PERIPH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lp_enter,
    input logic [NUM_PERIPH-1:0] periph_irq,
    input logic [NUM_PERIPH-1:0] ppm_disable,
    input logic                  drain_done,
    input logic                  wake_synced,
    input logic                  cpu_clk_en,
    input logic                  sram_clk_en,
    input logic                  memc_clk_en,
    input logic [NUM_PERIPH-1:0] periph_clk_en,
    input logic                  doze_ind,
    input logic [1:0]            mode_status,
    input logic                  drain_busy
);
    assert_wait_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b01) |-> (!cpu_clk_en && !sram_clk_en && memc_clk_en && !doze_ind));

    assert_doze_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b10) |-> (!cpu_clk_en && !sram_clk_en && memc_clk_en && doze_ind));

    assert_irq_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_status == 2'b01 || mode_status == 2'b10) && |(periph_irq & ~ppm_disable))
        |=> (mode_status == 2'b00 && cpu_clk_en && sram_clk_en));

    assert_disable_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_clk_en & ppm_disable) == '0);

    assert_stay_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b00 && !drain_busy && !lp_enter) |=> (mode_status == 2'b00 && !drain_busy));

    assert_drain_clocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drain_busy |-> (cpu_clk_en && sram_clk_en && memc_clk_en && mode_status == 2'b00));

    assert_drain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_busy && !drain_done) |=> drain_busy);

    assert_stop_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b11) |-> (!cpu_clk_en && !sram_clk_en && !memc_clk_en
                                    && periph_clk_en == '0 && !doze_ind));

    assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b11 && !wake_synced) |=> (mode_status == 2'b11));

    assert_stop_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_status == 2'b11 && wake_synced) |=> (mode_status == 2'b00 && cpu_clk_en));
endmodule

bind lp_clock_ctrl lpc_checker #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lp_enter      (lp_enter),
    .periph_irq    (periph_irq),
    .ppm_disable   (ppm_disable),
    .drain_done    (drain_done),
    .wake_synced   (wake_synced),
    .cpu_clk_en    (cpu_clk_en),
    .sram_clk_en   (sram_clk_en),
    .memc_clk_en   (memc_clk_en),
    .periph_clk_en (periph_clk_en),
    .doze_ind      (doze_ind),
    .mode_status   (mode_status),
    .drain_busy    (drain_busy)
);

// File: tb/sim_lp_clock_ctrl.sv
`timescale 1ns/1ps
module sim_lp_clock_ctrl;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lp_mode_req = 2'b00;
    logic          lp_enter = 1'b0;
    logic [NP-1:0] periph_irq = '0;
    logic [NP-1:0] ppm_disable = '0;
    logic          drain_done = 1'b0;
    logic          stop_wake = 1'b0;
    logic          cpu_clk_en, sram_clk_en, memc_clk_en, doze_ind, drain_busy;
    logic [NP-1:0] periph_clk_en;
    logic [1:0]    mode_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lp_clock_ctrl #(.NUM_PERIPH(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .lp_mode_req(lp_mode_req), .lp_enter(lp_enter),
        .periph_irq(periph_irq), .ppm_disable(ppm_disable), .drain_done(drain_done),
        .stop_wake(stop_wake), .cpu_clk_en(cpu_clk_en), .sram_clk_en(sram_clk_en),
        .memc_clk_en(memc_clk_en), .periph_clk_en(periph_clk_en), .doze_ind(doze_ind),
        .mode_status(mode_status), .drain_busy(drain_busy)
    );

    // {mode[1:0], irq[3:0], disable[3:0], wakes}
    localparam logic [10:0] VEC [8] = '{
        {2'b01, 4'b0001, 4'b0000, 1'b1},
        {2'b01, 4'b0010, 4'b0010, 1'b0},
        {2'b01, 4'b0100, 4'b0001, 1'b1},
        {2'b01, 4'b0000, 4'b0000, 1'b0},
        {2'b10, 4'b1000, 4'b0000, 1'b1},
        {2'b10, 4'b0001, 4'b0001, 1'b0},
        {2'b10, 4'b0110, 4'b0100, 1'b1},
        {2'b10, 4'b1111, 4'b1111, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input logic [1:0] m, input logic [NP-1:0] dis,
                                 input logic busy_e, input string tag);
        logic run_e, memc_e, doze_e;
        logic [NP-1:0] per_e;
        run_e  = (m == 2'b00);
        memc_e = (m != 2'b11);
        doze_e = (m == 2'b10);
        per_e  = (m == 2'b11) ? '0 : ~dis;
        chk(mode_status == m, tag, 8'(mode_status), 8'(m));
        chk(cpu_clk_en == run_e, tag, 8'(cpu_clk_en), 8'(run_e));
        chk(sram_clk_en == run_e, tag, 8'(sram_clk_en), 8'(run_e));
        chk(memc_clk_en == memc_e, tag, 8'(memc_clk_en), 8'(memc_e));
        chk(periph_clk_en == per_e, tag, 8'(periph_clk_en), 8'(per_e));
        chk(doze_ind == doze_e, tag, 8'(doze_ind), 8'(doze_e));
        chk(drain_busy == busy_e, tag, 8'(drain_busy), 8'(busy_e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lp_enter = 1'b0; periph_irq = '0; drain_done = 1'b0; stop_wake = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic enter_mode(input logic [1:0] m);
        lp_mode_req = m;
        lp_enter = 1'b1;
        step();
        lp_enter = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a disable pattern applied
        ppm_disable = 4'b0101;
        do_reset();
        check_outputs(2'b00, 4'b0101, 1'b0, "R1");

        // R7: disable bits mask peripheral enables in run and wait
        enter_mode(2'b01);
        check_outputs(2'b01, 4'b0101, 1'b0, "R7");

        // table walk: R3/R4 gating, R5 wake, R6 masked interrupts
        for (int i = 0; i < 8; i++) begin
            logic [1:0] m;
            logic [NP-1:0] irq_v, dis_v;
            logic wk;
            string tg;
            {m, irq_v, dis_v, wk} = VEC[i];
            ppm_disable = dis_v;
            do_reset();
            enter_mode(m);
            check_outputs(m, dis_v, 1'b0, (m == 2'b01) ? "R3" : "R4");
            periph_irq = irq_v;
            step();
            periph_irq = '0;
            tg = wk ? "R5" : "R6";
            check_outputs(wk ? 2'b00 : m, dis_v, 1'b0, tg);
        end

        // R2: strobe with request 00 does nothing
        ppm_disable = '0;
        do_reset();
        enter_mode(2'b00);
        check_outputs(2'b00, 4'b0000, 1'b0, "R2");
        // R2: request change without strobe does nothing
        lp_mode_req = 2'b10;
        step();
        step();
        check_outputs(2'b00, 4'b0000, 1'b0, "R2");
        // R2: strobe while in wait is ignored
        enter_mode(2'b01);
        enter_mode(2'b11);
        check_outputs(2'b01, 4'b0000, 1'b0, "R2");
        step();
        check_outputs(2'b01, 4'b0000, 1'b0, "R2");

        // R8: drain holds clocks until completion
        do_reset();
        enter_mode(2'b11);
        check_outputs(2'b00, 4'b0000, 1'b1, "R8");
        step();
        step();
        check_outputs(2'b00, 4'b0000, 1'b1, "R8");
        drain_done = 1'b1;
        step();
        drain_done = 1'b0;
        // R9: stop removes every enable
        check_outputs(2'b11, 4'b0000, 1'b0, "R9");
        periph_irq = 4'b1111;
        step();
        periph_irq = '0;
        check_outputs(2'b11, 4'b0000, 1'b0, "R9");

        // R10: wake through two synchroniser stages
        stop_wake = 1'b1;
        step();
        check_outputs(2'b11, 4'b0000, 1'b0, "R10");
        step();
        check_outputs(2'b11, 4'b0000, 1'b0, "R10");
        step();
        stop_wake = 1'b0;
        check_outputs(2'b00, 4'b0000, 1'b0, "R10");
        step();
        check_outputs(2'b00, 4'b0000, 1'b0, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule